// File: doc/BRIEF.md
# Parcel Instruction Decoder

This block holds one 64-bit instruction word and decodes the instruction that starts at its current 16-bit parcel. An instruction fills one parcel (16 bits) or two parcels (32 bits). The upper nibble of the first byte picks the encoding:

- In the two-operand form, a full byte of opcode is followed by two 4-bit register fields.
- In the three-operand form, a 4-bit opcode is followed by three 4-bit register fields.

In the long forms, the last register field and the following parcel together make a 20-bit constant.

Inputs and outputs:

- The surrounding fetch logic loads a word with `load_i`.
- The execute side reads the decoded fields.
- The execute side pulses `step_i` to move past the current instruction.
- The decoder reports the current and next parcel positions.
- It flags when a step carries it past the last parcel, so that a new word has to be fetched.
- It refuses to step over a long instruction that would cross the word boundary.

Top module: `pdec_top`

## Requirements
- R1: After reset `valid_o` is 0, `need_word_o` is 1, and `ptr_o`, `next_ptr_o`, `wrap_o`, `fault_o` and every decoded field are 0.
- R2: A cycle with `load_i` high stores `word_i`. From the next cycle `valid_o` is 1, `need_word_o` is 0 and `ptr_o` is 0. Parcel n of the word is `word_i[63-16n -: 16]`, so parcel 0 is the most significant.
- R3: When the top nibble of the first byte is 0 to 4, the instruction uses the two-operand form:
  - `opcode_o` is the first byte and `ri_o` is 0.
  - `rj_o` is bits 7:4 of the parcel.
  - `rk_o` is bits 3:0 of the parcel.
- R4: When the top nibble is 5 to F, the instruction uses the three-operand form:
  - `opcode_o` is that nibble followed by four zero bits.
  - `ri_o` is bits 11:8 of the parcel.
  - `rj_o` and `rk_o` come from the same bits as in R3.
- R5: `len32_o` is 1 for the following first bytes, and 0 for every other byte:
  - 10 to 13.
  - 20, 22, 24, 26, 28, 29 and 2A.
  - 30 to 3F, except 39, 3B and 3F.
  - Any byte whose top nibble is 4, 5, B, C or E.
- R6: For a long instruction, `rk_o` is 0 and `imm_o` is the low nibble of the first parcel followed by all 16 bits of the next parcel. For a short instruction, `imm_o` is 0.
- R7: `cls_o` is:
  - 0 for first byte 00 (error stop).
  - 1 for 0F (no-op).
  - 2 for any other two-operand byte.
  - 3 for the three-operand form.
- R8: `next_ptr_o` is `ptr_o` plus 1 for a short instruction or plus 2 for a long one, modulo 4. A step that does not wrap sets `ptr_o` to that value in the next cycle.
- R9: `wrap_o` is 1 when that sum reaches 4. A step while `wrap_o` is 1 leaves `valid_o` at 0, `need_word_o` at 1 and `ptr_o` at 0 in the next cycle.
- R10: A long instruction at parcel 3 raises `fault_o`. In that case `next_ptr_o` equals `ptr_o`, `wrap_o` is 0, and a step changes nothing.
- R11: `load_i` takes priority over `step_i`. While `valid_o` is 0, a step has no effect and all decoded fields are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Store a new instruction word |
| word_i | input | 64 | Instruction word, four parcels |
| step_i | input | 1 | Move past the current instruction |
| valid_o | output | 1 | A word is held and the decode is meaningful |
| need_word_o | output | 1 | No word held; fetch one |
| ptr_o | output | 2 | Current parcel position |
| next_ptr_o | output | 2 | Parcel position after the current instruction |
| wrap_o | output | 1 | Current instruction ends the word |
| fault_o | output | 1 | Long instruction would cross the word boundary |
| cls_o | output | 2 | Opcode class: 0 stop, 1 no-op, 2 two-operand, 3 three-operand |
| opcode_o | output | 8 | Opcode (three-operand form: nibble then zeros) |
| ri_o | output | 4 | Destination register (three-operand form only) |
| rj_o | output | 4 | First operand register |
| rk_o | output | 4 | Second operand register (short forms only) |
| imm_o | output | 20 | Constant of a long instruction |
| len32_o | output | 1 | Instruction fills two parcels |

## Verification
The decode outputs are combinational from the held word and pointer. A load or a step therefore shows its effect one clock edge later, and nothing takes longer. The bench drives every input on the falling edge and samples all outputs on the next falling edge, so each check lands in the cycle right after the edge that consumed its stimulus. The sweep places every possible first byte at each of the four parcel positions. It reaches the position by stepping over single-parcel no-ops, then steps once more and checks the advance, wrap or fault outcome one cycle later.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
    localparam int PARCEL_W  = 16;
    localparam int NPARCEL   = 4;
    localparam int WORD_W    = PARCEL_W * NPARCEL;
    localparam int PTR_W     = $clog2(NPARCEL);
    localparam int REG_W     = 4;
    localparam int OPC_W     = 2 * REG_W;
    localparam int IMM_W     = REG_W + PARCEL_W;
    localparam int THREE_MIN = 5;

    typedef enum logic [1:0] {
        CLS_HALT  = 2'd0,
        CLS_NOP   = 2'd1,
        CLS_TWO   = 2'd2,
        CLS_THREE = 2'd3
    } cls_e;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        cls_e             cls;
        logic [REG_W-1:0] ri;
        logic [REG_W-1:0] rj;
        logic [REG_W-1:0] rk;
        logic [IMM_W-1:0] imm;
        logic             len32;
    } dec_s;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [PTR_W-1:0]  ptr;
        logic              have;
    } st_s;
endpackage

// File: rtl/pdec_parcel_sel.sv
module pdec_parcel_sel
    import pdec_pkg::*;
(
    input  logic [WORD_W-1:0]   word_i,
    input  logic [PTR_W-1:0]    ptr_i,
    output logic [PARCEL_W-1:0] first_o,
    output logic [PARCEL_W-1:0] second_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NPARCEL - 1);

    logic [PARCEL_W-1:0] parcels [NPARCEL];

    // Parcel 0 sits in the most significant bits.
    for (genvar n = 0; n < NPARCEL; n++) begin : g_parcel
        assign parcels[n] = word_i[WORD_W-1-n*PARCEL_W -: PARCEL_W];
    end

    assign first_o  = parcels[ptr_i];
    assign second_o = (ptr_i == LAST) ? '0 : parcels[ptr_i + 1'b1];
endmodule

// File: rtl/pdec_len.sv
module pdec_len
    import pdec_pkg::*;
(
    input  logic [OPC_W-1:0] byte_i,
    output logic             len32_o
);
    logic [REG_W-1:0] hi;
    logic [REG_W-1:0] lo;

    assign hi = byte_i[OPC_W-1 -: REG_W];
    assign lo = byte_i[REG_W-1:0];

    // Long when the opcode carries an address, offset or constant.
    always_comb begin
        case (hi)
            4'h1:                      len32_o = (lo <= 4'h3);
            4'h2:                      len32_o = (lo <= 4'hA) && (!lo[0] || lo == 4'h9);
            4'h3:                      len32_o = !(lo == 4'h9 || lo == 4'hB || lo == 4'hF);
            4'h4, 4'h5, 4'hB, 4'hC,
            4'hE:                      len32_o = 1'b1;
            default:                   len32_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pdec_fields.sv
module pdec_fields
    import pdec_pkg::*;
(
    input  logic [PARCEL_W-1:0] first_i,
    input  logic [PARCEL_W-1:0] second_i,
    input  logic                len32_i,
    output dec_s                dec_o
);
    localparam logic [REG_W-1:0] THREE_LO = REG_W'(THREE_MIN);

    logic [REG_W-1:0] hi;
    logic [OPC_W-1:0] byte0;
    logic             three;

    assign hi    = first_i[PARCEL_W-1 -: REG_W];
    assign byte0 = first_i[PARCEL_W-1 -: OPC_W];
    assign three = (hi >= THREE_LO);

    always_comb begin
        dec_o       = '0;
        dec_o.len32 = len32_i;
        dec_o.rj    = first_i[2*REG_W-1 -: REG_W];
        if (three) begin
            dec_o.opcode = {hi, {REG_W{1'b0}}};
            dec_o.ri     = first_i[3*REG_W-1 -: REG_W];
            dec_o.cls    = CLS_THREE;
        end else begin
            dec_o.opcode = byte0;
            if (byte0 == '0) begin
                dec_o.cls = CLS_HALT;
            end else if (byte0 == OPC_W'(8'h0F)) begin
                dec_o.cls = CLS_NOP;
            end else begin
                dec_o.cls = CLS_TWO;
            end
        end
        if (len32_i) begin
            dec_o.imm = {first_i[REG_W-1:0], second_i};
        end else begin
            dec_o.rk  = first_i[REG_W-1:0];
        end
    end
endmodule

// File: rtl/pdec_ptr.sv
module pdec_ptr
    import pdec_pkg::*;
(
    input  logic             have_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic             len32_i,
    output logic [PTR_W-1:0] next_o,
    output logic             wrap_o,
    output logic             fault_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NPARCEL - 1);

    logic [PTR_W:0] sum;

    assign sum     = {1'b0, ptr_i} + (PTR_W+1)'(len32_i ? 2 : 1);
    assign fault_o = have_i && len32_i && (ptr_i == LAST);
    assign wrap_o  = have_i && !fault_o && sum[PTR_W];

    always_comb begin
        if (!have_i) begin
            next_o = '0;
        end else if (fault_o) begin
            next_o = ptr_i;
        end else begin
            next_o = sum[PTR_W-1:0];
        end
    end
endmodule

// File: rtl/pdec_top.sv
module pdec_top
    import pdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              step_i,
    output logic              valid_o,
    output logic              need_word_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [PTR_W-1:0]  next_ptr_o,
    output logic              wrap_o,
    output logic              fault_o,
    output logic [1:0]        cls_o,
    output logic [OPC_W-1:0]  opcode_o,
    output logic [REG_W-1:0]  ri_o,
    output logic [REG_W-1:0]  rj_o,
    output logic [REG_W-1:0]  rk_o,
    output logic [IMM_W-1:0]  imm_o,
    output logic              len32_o
);
    st_s st_d;
    st_s st_q;

    logic [PARCEL_W-1:0] first;
    logic [PARCEL_W-1:0] second;
    logic                len32;
    dec_s                dec;
    dec_s                dec_g;
    logic [PTR_W-1:0]    nxt;
    logic                wrap;
    logic                fault;

    pdec_parcel_sel u_sel (
        .word_i   (st_q.word),
        .ptr_i    (st_q.ptr),
        .first_o  (first),
        .second_o (second)
    );

    pdec_len u_len (
        .byte_i  (first[PARCEL_W-1 -: OPC_W]),
        .len32_o (len32)
    );

    pdec_fields u_fields (
        .first_i  (first),
        .second_i (second),
        .len32_i  (len32),
        .dec_o    (dec)
    );

    pdec_ptr u_ptr (
        .have_i  (st_q.have),
        .ptr_i   (st_q.ptr),
        .len32_i (len32),
        .next_o  (nxt),
        .wrap_o  (wrap),
        .fault_o (fault)
    );

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.word = word_i;
            st_d.ptr  = '0;
            st_d.have = 1'b1;
        end else if (step_i && st_q.have && !fault) begin
            if (wrap) begin
                st_d.ptr  = '0;
                st_d.have = 1'b0;
            end else begin
                st_d.ptr  = nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_g       = st_q.have ? dec : '0;
    assign valid_o     = st_q.have;
    assign need_word_o = !st_q.have;
    assign ptr_o       = st_q.ptr;
    assign next_ptr_o  = nxt;
    assign wrap_o      = wrap;
    assign fault_o     = fault;
    assign cls_o       = dec_g.cls;
    assign opcode_o    = dec_g.opcode;
    assign ri_o        = dec_g.ri;
    assign rj_o        = dec_g.rj;
    assign rk_o        = dec_g.rk;
    assign imm_o       = dec_g.imm;
    assign len32_o     = dec_g.len32;

    // R2: a load yields a valid word positioned at parcel 0
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (valid_o && ptr_o == '0));

    // R8: a plain step moves to the announced next parcel
    a_r8_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && step_i && !load_i && !wrap_o && !fault_o)
        |=> (valid_o && ptr_o == $past(next_ptr_o)));

    // R9: stepping off the end of the word asks for a new one
    a_r9_wrap_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && wrap_o && step_i && !load_i)
        |=> (!valid_o && need_word_o && ptr_o == '0));

    // R10: a boundary-crossing instruction blocks the step
    a_r10_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && step_i && !load_i) |=> (valid_o && $stable(ptr_o) && fault_o));

    // R11: nothing but a load makes the decoder valid again
    a_r11_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !load_i) |=> (!valid_o && opcode_o == '0 && imm_o == '0));
endmodule

// File: tb/tb_pdec_top.sv
`timescale 1ns/1ps
module tb_pdec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [63:0] word_i = '0;
    logic        step_i = 1'b0;
    logic        valid_o, need_word_o, wrap_o, fault_o, len32_o;
    logic [1:0]  ptr_o, next_ptr_o, cls_o;
    logic [7:0]  opcode_o;
    logic [3:0]  ri_o, rj_o, rk_o;
    logic [19:0] imm_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pdec_top dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .word_i(word_i), .step_i(step_i),
        .valid_o(valid_o), .need_word_o(need_word_o), .ptr_o(ptr_o),
        .next_ptr_o(next_ptr_o), .wrap_o(wrap_o), .fault_o(fault_o), .cls_o(cls_o),
        .opcode_o(opcode_o), .ri_o(ri_o), .rj_o(rj_o), .rk_o(rk_o), .imm_o(imm_o),
        .len32_o(len32_o)
    );

    function automatic logic [50:0] obs();
        return {valid_o, need_word_o, ptr_o, next_ptr_o, wrap_o, fault_o, cls_o,
                opcode_o, ri_o, rj_o, rk_o, imm_o, len32_o};
    endfunction

    // Length rule of R5
    function automatic logic is_long(logic [7:0] b);
        int lo;
        lo = int'(b[3:0]);
        case (b[7:4])
            4'h1: return lo < 4;
            4'h2: return lo == 0 || lo == 2 || lo == 4 || lo == 6 || lo == 8 || lo == 9 || lo == 10;
            4'h3: return !(lo == 9 || lo == 11 || lo == 15);
            4'h4, 4'h5, 4'hB, 4'hC, 4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Expected port values from R1-style idle state or R3..R10 decode
    function automatic logic [50:0] expv(logic v, logic [1:0] p, logic [15:0] f, logic [15:0] s);
        logic       three, l32, flt, wr;
        logic [1:0] cls, np;
        logic [7:0] op;
        logic [3:0] ri, rk;
        logic [19:0] imm;
        int         sum;
        if (!v) return {1'b0, 1'b1, 49'd0};
        three = (f[15:12] >= 4'd5);
        l32   = is_long(f[15:8]);
        flt   = l32 && (p == 2'd3);
        sum   = int'(p) + (l32 ? 2 : 1);
        wr    = !flt && (sum >= 4);
        np    = flt ? p : 2'(sum % 4);
        if (three)                  cls = 2'd3;
        else if (f[15:8] == 8'h00)  cls = 2'd0;
        else if (f[15:8] == 8'h0F)  cls = 2'd1;
        else                        cls = 2'd2;
        op  = three ? {f[15:12], 4'h0} : f[15:8];
        ri  = three ? f[11:8] : 4'h0;
        rk  = l32 ? 4'h0 : f[3:0];
        imm = l32 ? {f[3:0], s} : 20'h0;
        return {1'b1, 1'b0, p, np, wr, flt, cls, op, ri, f[7:4], rk, imm, l32};
    endfunction

    task automatic chk(string tag, logic [50:0] got, logic [50:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] parcel_of(logic [63:0] w, int n);
        if (n > 3) return 16'h0;
        return w[63-16*n -: 16];
    endfunction

    task automatic load_word(logic [63:0] w);
        @(negedge clk);
        load_i = 1'b1;
        word_i = w;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic step_once();
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] w;
        logic [7:0]  rb;
        logic [15:0] ext;
        int          adv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", obs(), expv(1'b0, 2'd0, 16'h0, 16'h0));

        // R11: a step with no word held changes nothing
        step_once();
        chk("R11 step while empty", obs(), expv(1'b0, 2'd0, 16'h0, 16'h0));

        // Sweep of every first byte at every parcel position
        for (int b = 0; b < 256; b++) begin
            for (int p = 0; p < 4; p++) begin
                rb  = 8'(b) ^ 8'h5A;
                ext = {8'(b) ^ 8'hC3, 8'(b) + 8'(p)};
                for (int q = 0; q < 4; q++) begin
                    if (q == p)          w[63-16*q -: 16] = {8'(b), rb};
                    else if (q == p + 1) w[63-16*q -: 16] = ext;
                    else                 w[63-16*q -: 16] = 16'h0F00;
                end
                load_word(w);
                // R2: parcel 0 is the top of the word
                chk("R2 load", obs(), expv(1'b1, 2'd0, parcel_of(w, 0), parcel_of(w, 1)));
                for (int s = 0; s < p; s++) step_once();
                // R3 R4 R5 R6 R7 decode of the placed instruction
                chk((b >= 8'h50) ? "R4 R5 R6 R7 three-operand decode"
                                 : "R3 R5 R6 R7 two-operand decode",
                    obs(), expv(1'b1, 2'(p), parcel_of(w, p), parcel_of(w, p + 1)));
                adv = is_long(8'(b)) ? 2 : 1;
                step_once();
                if (adv == 2 && p == 3) begin
                    chk("R10 fault blocks step", obs(),
                        expv(1'b1, 2'd3, parcel_of(w, 3), 16'h0));
                end else if (p + adv >= 4) begin
                    chk("R9 wrap empties", obs(), expv(1'b0, 2'd0, 16'h0, 16'h0));
                end else begin
                    chk("R8 advance", obs(),
                        expv(1'b1, 2'(p + adv), parcel_of(w, p + adv), parcel_of(w, p + adv + 1)));
                end
            end
        end

        // R11: load beats a simultaneous step
        load_word(64'h0F00_0F00_0F00_0F00);
        step_once();
        @(negedge clk);
        load_i = 1'b1;
        step_i = 1'b1;
        word_i = 64'h6123_0F00_0F00_0F00;
        @(negedge clk);
        load_i = 1'b0;
        step_i = 1'b0;
        chk("R11 load over step", obs(), expv(1'b1, 2'd0, 16'h6123, 16'h0F00));

        // R7 halt and no-op codes at parcel 0
        load_word(64'h0000_0F00_0F00_0F00);
        chk("R7 halt class", obs(), expv(1'b1, 2'd0, 16'h0000, 16'h0F00));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule